// File: doc/BRIEF.md
# Pad Calibration and Refresh Sequencer

This block runs the calibration of the delay-locked loop and of the output pad impedance for a high-speed serial memory interface. A start command powers up the analog circuits, waits a programmable start-up delay so that they settle, and then raises a request to the calibration cell. The sequence holds that request until the cell acknowledges it. While the request is up, the block produces a calibration clock enable at the peripheral clock rate divided by a programmable factor. A busy output covers the start-up wait and the request phase.

A keep-powered option leaves the analog circuits on after a calibration. A later calibration then skips the start-up wait. Separate enable and disable commands drive the DLL, and the block reports the lock state as a registered status.

After the first calibration has finished, a programmable refresh period starts further calibrations automatically. The block marks each completed automatic calibration with a sticky flag, which a status-read strobe clears. A refresh period of zero turns automatic calibration off.

Top module: `padcal_sequencer`

## Requirements
- R1: After reset the outputs cal_busy_o, ana_req_o, ana_pwr_o, dll_en_o, dll_locked_o and refresh_done_o are all 0.
- R2: The block accepts a start command only when it is idle. The edge that samples the command raises cal_busy_o and ana_pwr_o. If the analog circuits are cold, ana_req_o rises exactly N cycles later, where N is cfg_startup_i. A value of 0 gives no wait.
- R3: If cfg_keep_on_i is 1 when a calibration completes, ana_pwr_o stays 1 while idle, and the next calibration raises ana_req_o on the same edge as cal_busy_o. Clearing cfg_keep_on_i lowers ana_pwr_o on the next edge, and the start-up wait applies again.
- R4: ana_clk_en_o pulses only while ana_req_o is 1. It pulses in the first request cycle and then every cfg_clk_div_i+1 cycles, which is ceil(A/(D+1)) pulses over A request cycles.
- R5: ana_ack_i sampled while ana_req_o is 1 ends the calibration, and both ana_req_o and cal_busy_o are 0 after that edge. An ana_ack_i outside the request phase has no effect.
- R6: A start command while cal_busy_o is 1 is ignored. It does not shift the calibration and does not start a second one afterwards.
- R7: cmd_dll_on_i sets dll_en_o on the next edge, and cmd_dll_off_i clears it (off wins). dll_locked_o is dll_lock_i registered while the DLL is enabled, and it falls on the edge that samples cmd_dll_off_i whatever dll_lock_i is.
- R8: With cfg_refresh_i = P (non-zero), cal_busy_o stays low for exactly P cycles after each completed calibration. An automatic calibration then starts, using the same start-up rule as a commanded one.
- R9: With cfg_refresh_i = 0, no automatic calibration starts.
- R10: refresh_done_o is set on the edge where an automatic calibration completes, but not for a commanded one. It holds until a stat_rd_i strobe clears it on the next edge. If setting and clearing fall on the same edge, the set wins.
- R11: No automatic calibration starts before the first calibration after reset has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_startup_i | input | STARTUP_W | Start-up wait in clock cycles |
| cfg_keep_on_i | input | 1 | Keep analog circuits powered between calibrations |
| cfg_clk_div_i | input | DIV_W | Calibration clock divider minus one |
| cfg_refresh_i | input | REF_W | Automatic recalibration period in cycles, 0 = off |
| cmd_dll_on_i | input | 1 | DLL enable command pulse |
| cmd_dll_off_i | input | 1 | DLL disable command pulse |
| cmd_cal_start_i | input | 1 | Calibration start command pulse |
| stat_rd_i | input | 1 | Status read strobe, clears refresh_done_o |
| ana_pwr_o | output | 1 | Analog circuit power enable |
| ana_req_o | output | 1 | Calibration request to the calibration cell |
| ana_clk_en_o | output | 1 | Divided calibration clock enable |
| ana_ack_i | input | 1 | Calibration complete from the calibration cell |
| dll_en_o | output | 1 | DLL enable |
| dll_lock_i | input | 1 | Lock indication from the DLL |
| cal_busy_o | output | 1 | Calibration in progress |
| dll_locked_o | output | 1 | Registered DLL lock status |
| refresh_done_o | output | 1 | Sticky automatic calibration completed flag |

## Verification
The edge that samples a start command sets busy and power, so the bench checks them at the falling edge that follows. The request then comes exactly cfg_startup_i cycles later, or in that same cycle when the circuits are warm. Request and busy drop one edge after a sampled acknowledge, the DLL enable and lock status follow their commands and input after one edge, and the refresh flag sets or clears one edge after its cause. An automatic calibration raises busy on the edge after the refresh period has run out. The bench samples every output at the falling edge and counts falling edges from the stimulus to the change, so each result is compared in the exact cycle these latencies give.

// File: rtl/padcal_pkg.sv
package padcal_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_WARM = 2'd1,
        CAL_RUN  = 2'd2
    } cal_state_e;

endpackage

// File: rtl/padcal_clk_div.sv
module padcal_clk_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_regs_t;

    div_regs_t div_d, div_q;

    // Counter rests at zero while disabled, so the first enabled cycle ticks.
    always_comb begin
        div_d = div_q;
        if (!en_i) begin
            div_d.cnt = '0;
        end else if (div_q.cnt >= div_i) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    assign tick_o = en_i && (div_q.cnt == '0);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/padcal_refresh_timer.sv
module padcal_refresh_timer #(
    parameter int REF_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [REF_W-1:0] period_i,
    output logic             fire_o
);

    localparam logic [REF_W-1:0] ONE = {{(REF_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [REF_W-1:0] cnt;
    } ref_regs_t;

    ref_regs_t ref_d, ref_q;
    logic      period_nz;

    assign period_nz = (period_i != '0);
    // A compare with >= keeps the timer firing if the period shrinks mid-count.
    assign fire_o    = run_i && period_nz && (ref_q.cnt >= (period_i - ONE));

    always_comb begin
        ref_d = ref_q;
        if (clear_i) begin
            ref_d.cnt = '0;
        end else if (run_i && period_nz) begin
            if (fire_o) begin
                ref_d.cnt = '0;
            end else begin
                ref_d.cnt = ref_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ref_q <= '0;
        end else begin
            ref_q <= ref_d;
        end
    end

endmodule

// File: rtl/padcal_dll_track.sv
module padcal_dll_track (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic on_i,
    input  logic off_i,
    input  logic lock_i,
    output logic en_o,
    output logic locked_o
);

    typedef struct packed {
        logic en;
        logic locked;
    } dll_regs_t;

    dll_regs_t dll_d, dll_q;

    always_comb begin
        dll_d = dll_q;
        if (off_i) begin
            dll_d.en = 1'b0;
        end else if (on_i) begin
            dll_d.en = 1'b1;
        end
        // Lock is only reported while the loop is (or becomes) enabled.
        dll_d.locked = dll_d.en && lock_i;
    end

    assign en_o     = dll_q.en;
    assign locked_o = dll_q.locked;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dll_q <= '0;
        end else begin
            dll_q <= dll_d;
        end
    end

endmodule

// File: rtl/padcal_sequencer.sv
module padcal_sequencer
    import padcal_pkg::*;
#(
    parameter int STARTUP_W = 9,
    parameter int DIV_W     = 3,
    parameter int REF_W     = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [STARTUP_W-1:0] cfg_startup_i,
    input  logic                 cfg_keep_on_i,
    input  logic [DIV_W-1:0]     cfg_clk_div_i,
    input  logic [REF_W-1:0]     cfg_refresh_i,
    input  logic                 cmd_dll_on_i,
    input  logic                 cmd_dll_off_i,
    input  logic                 cmd_cal_start_i,
    input  logic                 stat_rd_i,
    output logic                 ana_pwr_o,
    output logic                 ana_req_o,
    output logic                 ana_clk_en_o,
    input  logic                 ana_ack_i,
    output logic                 dll_en_o,
    input  logic                 dll_lock_i,
    output logic                 cal_busy_o,
    output logic                 dll_locked_o,
    output logic                 refresh_done_o
);

    localparam logic [STARTUP_W-1:0] WAIT_ONE = {{(STARTUP_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        cal_state_e           st;
        logic [STARTUP_W-1:0] wait_cnt;
        logic                 warm;
        logic                 is_refresh;
        logic                 ran_once;
        logic                 ref_done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic ref_fire;
    logic ref_run;
    logic cal_end;
    logic start_ok;

    assign cal_end  = (seq_q.st == CAL_RUN) && ana_ack_i;
    assign start_ok = (seq_q.st == CAL_IDLE) && (cmd_cal_start_i || ref_fire);
    assign ref_run  = (seq_q.st == CAL_IDLE) && seq_q.ran_once;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            CAL_IDLE: begin
                if (start_ok) begin
                    seq_d.is_refresh = !cmd_cal_start_i;
                    if (seq_q.warm || (cfg_startup_i == '0)) begin
                        seq_d.st = CAL_RUN;
                    end else begin
                        seq_d.st       = CAL_WARM;
                        seq_d.wait_cnt = cfg_startup_i - WAIT_ONE;
                    end
                end
            end
            CAL_WARM: begin
                if (seq_q.wait_cnt == '0) begin
                    seq_d.st = CAL_RUN;
                end else begin
                    seq_d.wait_cnt = seq_q.wait_cnt - WAIT_ONE;
                end
            end
            CAL_RUN: begin
                if (ana_ack_i) begin
                    seq_d.st       = CAL_IDLE;
                    seq_d.ran_once = 1'b1;
                end
            end
            default: seq_d.st = CAL_IDLE;
        endcase

        seq_d.warm = cfg_keep_on_i && (seq_q.warm || cal_end);

        if (cal_end && seq_q.is_refresh) begin
            seq_d.ref_done = 1'b1;
        end else if (stat_rd_i) begin
            seq_d.ref_done = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q    <= '0;
            seq_q.st <= CAL_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    padcal_clk_div #(
        .DIV_W (DIV_W)
    ) u_clk_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (seq_q.st == CAL_RUN),
        .div_i  (cfg_clk_div_i),
        .tick_o (ana_clk_en_o)
    );

    padcal_refresh_timer #(
        .REF_W (REF_W)
    ) u_refresh (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (ref_run),
        .clear_i  (cal_end),
        .period_i (cfg_refresh_i),
        .fire_o   (ref_fire)
    );

    padcal_dll_track u_dll (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .on_i     (cmd_dll_on_i),
        .off_i    (cmd_dll_off_i),
        .lock_i   (dll_lock_i),
        .en_o     (dll_en_o),
        .locked_o (dll_locked_o)
    );

    assign cal_busy_o     = (seq_q.st != CAL_IDLE);
    assign ana_req_o      = (seq_q.st == CAL_RUN);
    assign ana_pwr_o      = (seq_q.st != CAL_IDLE) || seq_q.warm;
    assign refresh_done_o = seq_q.ref_done;

endmodule

// File: rtl/padcal_sequencer_chk.sv
module padcal_sequencer_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic ana_req_o,
    input logic ana_ack_i,
    input logic ana_clk_en_o,
    input logic ana_pwr_o,
    input logic cal_busy_o,
    input logic cmd_dll_off_i,
    input logic dll_en_o,
    input logic dll_lock_i,
    input logic dll_locked_o,
    input logic stat_rd_i,
    input logic refresh_done_o
);

    p_tick_in_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ana_clk_en_o |-> ana_req_o);

    p_req_powered_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ana_req_o |-> (ana_pwr_o && cal_busy_o));

    p_ack_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ana_req_o && ana_ack_i) |=> (!ana_req_o && !cal_busy_o));

    p_off_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_dll_off_i |=> (!dll_locked_o && !dll_en_o));

    p_lock_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dll_locked_o |-> (dll_en_o && $past(dll_lock_i)));

    p_rd_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_rd_i && !(ana_req_o && ana_ack_i)) |=> !refresh_done_o);

    p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (refresh_done_o && !stat_rd_i) |=> refresh_done_o);

endmodule

bind padcal_sequencer padcal_sequencer_chk u_padcal_chk (.*);

// File: tb/test_padcal_sequencer.sv
module test_padcal_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  cfg_startup = '0;
    logic        cfg_keep = 1'b0;
    logic [2:0]  cfg_div = '0;
    logic [31:0] cfg_refresh = '0;
    logic        dll_on = 1'b0;
    logic        dll_off = 1'b0;
    logic        start = 1'b0;
    logic        stat_rd = 1'b0;
    logic        ana_pwr, ana_req, ana_clk_en, dll_en, cal_busy, dll_locked, ref_done;
    logic        ack = 1'b0;
    logic        dll_lock = 1'b0;

    int nchk = 0;
    int nfail = 0;

    // {startup N [31:16], divider D [15:8], request length A [7:0]}
    localparam logic [31:0] VEC_TBL [6] = '{
        32'h0000_0003, 32'h0001_0001, 32'h0004_0105,
        32'h0009_0309, 32'h0002_0711, 32'h0014_0207
    };

    always #5 clk = ~clk;

    padcal_sequencer i_padcal_sequencer (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .cfg_startup_i   (cfg_startup),
        .cfg_keep_on_i   (cfg_keep),
        .cfg_clk_div_i   (cfg_div),
        .cfg_refresh_i   (cfg_refresh),
        .cmd_dll_on_i    (dll_on),
        .cmd_dll_off_i   (dll_off),
        .cmd_cal_start_i (start),
        .stat_rd_i       (stat_rd),
        .ana_pwr_o       (ana_pwr),
        .ana_req_o       (ana_req),
        .ana_clk_en_o    (ana_clk_en),
        .ana_ack_i       (ack),
        .dll_en_o        (dll_en),
        .dll_lock_i      (dll_lock),
        .cal_busy_o      (cal_busy),
        .dll_locked_o    (dll_locked),
        .refresh_done_o  (ref_done)
    );

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic run_cal(input int n, input int d, input int a, input bit keep,
                           input bit xtra_start, input bit early_ack,
                           input int exp_delay, input string tag);
        int delay;
        int ticks;
        @(negedge clk);
        cfg_startup = n[8:0];
        cfg_div     = d[2:0];
        cfg_keep    = keep;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R2 busy after start"}, int'(cal_busy), 1);
        chk({tag, " R2 power after start"}, int'(ana_pwr), 1);
        if (early_ack) ack = 1'b1;
        delay = 0;
        while (!ana_req && delay < 2000) begin
            @(negedge clk);
            ack = 1'b0;
            delay++;
        end
        ack = 1'b0;
        chk({tag, " R2/R3 request delay"}, delay, exp_delay);
        ticks = 0;
        for (int i = 0; i < a; i++) begin
            if (ana_clk_en) ticks++;
            if (xtra_start && i == 0) start = 1'b1;
            if (i == a - 1) ack = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        ack = 1'b0;
        chk({tag, " R4 clock enable pulses"}, ticks, (a + d) / (d + 1));
        chk({tag, " R5 request dropped"}, int'(ana_req), 0);
        chk({tag, " R5 busy dropped"}, int'(cal_busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int idle;
        int d;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(cal_busy), 0);
        chk("R1 request", int'(ana_req), 0);
        chk("R1 power", int'(ana_pwr), 0);
        chk("R1 dll enable", int'(dll_en), 0);
        chk("R1 lock", int'(dll_locked), 0);
        chk("R1 refresh done", int'(ref_done), 0);

        // R11: refresh period set but no calibration yet
        cfg_refresh = 32'd3;
        seen = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (cal_busy) seen = 1'b1;
        end
        chk("R11 no refresh before first calibration", int'(seen), 0);
        cfg_refresh = 32'd0;

        // Table of cold calibrations
        foreach (VEC_TBL[k]) begin
            run_cal(int'(VEC_TBL[k][31:16]), int'(VEC_TBL[k][15:8]),
                    int'(VEC_TBL[k][7:0]), 1'b0, 1'b0, 1'b0,
                    int'(VEC_TBL[k][31:16]), "table");
        end

        // R5: acknowledge while idle and during the start-up wait
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R5 idle ack busy", int'(cal_busy), 0);
        chk("R5 idle ack request", int'(ana_req), 0);
        run_cal(5, 0, 2, 1'b0, 1'b0, 1'b1, 5, "R5 early ack");

        // R6: start during busy ignored
        run_cal(3, 1, 4, 1'b0, 1'b1, 1'b0, 3, "R6");
        seen = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (cal_busy) seen = 1'b1;
        end
        chk("R6 no second calibration", int'(seen), 0);

        // R3: keep-powered skips the start-up wait
        run_cal(6, 0, 2, 1'b1, 1'b0, 1'b0, 6, "R3 first");
        chk("R3 power held while idle", int'(ana_pwr), 1);
        run_cal(6, 0, 2, 1'b1, 1'b0, 1'b0, 0, "R3 warm");
        cfg_keep = 1'b0;
        @(negedge clk);
        chk("R3 power off after keep cleared", int'(ana_pwr), 0);
        run_cal(6, 0, 2, 1'b0, 1'b0, 1'b0, 6, "R3 cold again");

        // R7: DLL control and lock tracking
        dll_lock = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 lock ignored while disabled", int'(dll_locked), 0);
        dll_on = 1'b1;
        @(negedge clk);
        dll_on = 1'b0;
        chk("R7 enable after on", int'(dll_en), 1);
        chk("R7 lock reported", int'(dll_locked), 1);
        dll_lock = 1'b0;
        @(negedge clk);
        chk("R7 lock follows input low", int'(dll_locked), 0);
        dll_lock = 1'b1;
        @(negedge clk);
        chk("R7 lock follows input high", int'(dll_locked), 1);
        dll_off = 1'b1;
        @(negedge clk);
        dll_off = 1'b0;
        chk("R7 off clears enable", int'(dll_en), 0);
        chk("R7 off clears lock", int'(dll_locked), 0);
        dll_lock = 1'b0;

        // R8 / R10: automatic calibrations
        cfg_refresh = 32'd5;
        run_cal(2, 0, 1, 1'b0, 1'b0, 1'b0, 2, "R8 command");
        chk("R10 not set by command", int'(ref_done), 0);
        idle = 1;
        while (idle < 1000) begin
            @(negedge clk);
            if (cal_busy) break;
            idle++;
        end
        chk("R8 idle gap", idle, 5);
        d = 0;
        while (!ana_req && d < 1000) begin
            @(negedge clk);
            d++;
        end
        chk("R8 refresh start-up wait", d, 2);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R10 set on refresh end", int'(ref_done), 1);
        repeat (2) @(negedge clk);
        chk("R10 sticky", int'(ref_done), 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R10 cleared by read", int'(ref_done), 0);
        d = 0;
        while (!ana_req && d < 1000) begin
            @(negedge clk);
            d++;
        end
        ack     = 1'b1;
        stat_rd = 1'b1;
        @(negedge clk);
        ack         = 1'b0;
        stat_rd     = 1'b0;
        cfg_refresh = 32'd0;
        chk("R10 set wins over read", int'(ref_done), 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R10 cleared after set", int'(ref_done), 0);

        // R9: period zero disables refresh
        seen = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (cal_busy) seen = 1'b1;
        end
        chk("R9 no refresh at period zero", int'(seen), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule